// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

The block judges whether an oscillator runs at the expected frequency. It counts edges of a comparison clock during a fixed window of oscillator edges and reports the signed count difference as an error sample, with a one-cycle strobe. From these samples it keeps a loss-of-lock flag with hysteresis. The flag rises when the error is well outside the band and falls only once the error is back close to zero. An acquisition controller reads the error samples. The flag, or a sticky copy of it, drives a single loss-of-lock pin.

Two comparison sources exist. In data mode the recovered data-rate clock is counted. In reference mode a reference clock is counted, and the window is stretched by a power-of-two ratio. This is the same as dividing the oscillator down to the reference rate. Each of the three clocks drives a free-running Gray counter in its own domain. Each counter is carried into the system clock domain through a two-flop synchronizer, so all decisions are taken in one domain. The system clock must be faster than the oscillator clock and both comparison clocks. With the default 4000-count window, one count is 250 ppm and four counts are 1000 ppm.

Top module: `freq_lock_detector`

## Requirements
- R1: When an error sample with magnitude above SET_CNT (4 counts, i.e. 1000 ppm at the default window) is strobed, `lol_live` is 1 on the following cycle.
- R2: When an error sample with magnitude of at most CLR_CNT (1 count, i.e. 250 ppm) is strobed, `lol_live` is 0 on the following cycle.
- R3: A sample whose magnitude lies strictly between the two thresholds leaves `lol_live` unchanged, and `lol_live` never changes in a cycle without a sample.
- R4: With `cfg_ref_mode` = 0, a window lasts WINDOW (4000) oscillator cycles. `err_sample` equals the number of `clk_data` edges in the window minus WINDOW, in two's complement.
- R5: With `cfg_ref_mode` = 1, a window lasts WINDOW·2^`cfg_div` oscillator cycles. `err_sample` equals the number of `clk_ref` edges in it minus WINDOW.
- R6: While and right after reset, `lol_live` = 1, `stat_sticky` = 1, `lol_pin` = 1 and `err_valid` = 0.
- R7: `stat_sticky` is 1 in every cycle where `lol_live` is 1, and it stays 1 after `lol_live` returns to 0.
- R8: A 1-then-0 sequence on `cfg_sticky_clr` clears `stat_sticky` on the cycle after the falling edge, if loss of lock is not active then. An active loss of lock in that cycle wins and keeps it at 1.
- R9: `lol_pin` shows `lol_live` when `cfg_pin_sticky` = 0 and `stat_sticky` when `cfg_pin_sticky` = 1.
- R10: Each completed window gives exactly one single-cycle `err_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; all outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset (synchronized into the other domains) |
| clk_osc | input | 1 | Divided oscillator clock that sets the window |
| clk_data | input | 1 | Recovered data-rate clock (data mode) |
| clk_ref | input | 1 | Reference clock (reference mode) |
| cfg_ref_mode | input | 1 | 0 = compare with data clock, 1 = compare with reference clock |
| cfg_div | input | DIV_W | Power-of-two ratio between oscillator and reference |
| cfg_sticky_clr | input | 1 | Sticky clear control; write 1 then 0 |
| cfg_pin_sticky | input | 1 | Pin source select: 0 live flag, 1 sticky flag |
| lol_pin | output | 1 | Loss-of-lock pin |
| lol_live | output | 1 | Live hysteretic loss-of-lock flag |
| stat_sticky | output | 1 | Sticky loss-of-lock status |
| err_sample | output | ERR_W | Signed count error of the last window |
| err_valid | output | 1 | One-cycle strobe for a new error sample |

## Verification
The sticky flag can receive a set and a clear in the same cycle: the falling edge of the clear control can land while loss of lock is active. The bench provokes this by issuing the 1-then-0 clear while the comparison clock is 2000 ppm off, so `lol_live` is held high. It expects `stat_sticky` to stay 1. A second clear is issued while lock holds, and there the bit must drop. A reference model of the hysteresis is fed with the observed samples and is compared at each window with the live flag, the sticky bit and the pin.

// File: rtl/flock_pkg.sv
package flock_pkg;

    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_SET  = 2'd1,
        DEC_CLR  = 2'd2
    } lol_dec_e;

    // counter width that covers the longest stretched window plus wrap margin
    function automatic int cnt_width(input int win, input int div_w);
        longint span;
        span = longint'(win) << ((1 << div_w) - 1);
        return $clog2(span) + 2;
    endfunction

    // count difference that corresponds to a ppm threshold over the window
    function automatic int ppm_to_cnt(input int win, input int ppm);
        return int'((longint'(win) * longint'(ppm)) / 64'd1000000);
    endfunction

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/flock_gray_cnt.sv
module flock_gray_cnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] gray
);
    logic [1:0]   rst_sync;
    logic [W-1:0] bin;

    always_ff @(posedge clk) begin
        rst_sync <= {rst_sync[0], rst};
    end

    always_ff @(posedge clk) begin
        if (rst_sync[1]) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin + 1'b1;
            gray <= W'(flock_pkg::bin2gray(32'(bin + 1'b1)));
        end
    end
endmodule

// File: rtl/flock_gray_sync.sv
module flock_gray_sync #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta, stable;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            stable <= '0;
        end else begin
            meta   <= gray_in;
            stable <= meta;
        end
    end

    assign bin_out = W'(flock_pkg::gray2bin(32'(stable)));
endmodule

// File: rtl/flock_window.sv
module flock_window #(
    parameter int WINDOW = 4000,
    parameter int DIV_W  = 2,
    parameter int CNT_W  = 17,
    parameter int ERR_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_mode,
    input  logic [DIV_W-1:0]        div,
    input  logic [CNT_W-1:0]        osc_now,
    input  logic [CNT_W-1:0]        dat_now,
    input  logic [CNT_W-1:0]        ref_now,
    output logic signed [ERR_W-1:0] err_sample,
    output logic                    err_valid
);
    logic             started;
    logic [CNT_W-1:0] osc_base, dat_base, ref_base;
    logic [CNT_W-1:0] osc_span, cmp_span, win_len;
    logic             win_done;

    always_comb begin
        osc_span = osc_now - osc_base;
        win_len  = ref_mode ? (CNT_W'(WINDOW) << div) : CNT_W'(WINDOW);
        cmp_span = ref_mode ? (ref_now - ref_base) : (dat_now - dat_base);
        win_done = started && (osc_span >= win_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started    <= 1'b0;
            osc_base   <= '0;
            dat_base   <= '0;
            ref_base   <= '0;
            err_valid  <= 1'b0;
            err_sample <= '0;
        end else begin
            err_valid <= 1'b0;
            if (!started || win_done) begin
                started  <= 1'b1;
                osc_base <= osc_now;
                dat_base <= dat_now;
                ref_base <= ref_now;
            end
            if (win_done) begin
                err_valid  <= 1'b1;
                err_sample <= $signed({1'b0, cmp_span}) - ERR_W'(WINDOW);
            end
        end
    end

    // oscillator count seen in the system domain advances by at most one per cycle
    assert_osc_step_R4: assert property (@(posedge clk) disable iff (rst)
        started |-> (CNT_W'(osc_now - $past(osc_now)) <= CNT_W'(1)));

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);
endmodule

// File: rtl/flock_lol.sv
module flock_lol #(
    parameter int ERR_W   = 18,
    parameter int SET_CNT = 4,
    parameter int CLR_CNT = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ERR_W-1:0] err,
    input  logic                    err_valid,
    input  logic                    sticky_clr,
    input  logic                    pin_sticky,
    output logic                    lol,
    output logic                    sticky,
    output logic                    pin
);
    import flock_pkg::*;

    logic [ERR_W-1:0] mag;
    lol_dec_e         dec;
    logic             lol_nxt, sticky_nxt, clr_q, clr_fall;

    always_comb begin
        mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
        dec = DEC_HOLD;
        if (err_valid) begin
            if (mag > ERR_W'(SET_CNT))       dec = DEC_SET;
            else if (mag <= ERR_W'(CLR_CNT)) dec = DEC_CLR;
        end
        case (dec)
            DEC_SET: lol_nxt = 1'b1;
            DEC_CLR: lol_nxt = 1'b0;
            default: lol_nxt = lol;
        endcase
        clr_fall   = clr_q && !sticky_clr;
        sticky_nxt = lol_nxt ? 1'b1 : (clr_fall ? 1'b0 : sticky);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lol    <= 1'b1;
            sticky <= 1'b1;
            clr_q  <= 1'b0;
        end else begin
            lol    <= lol_nxt;
            sticky <= sticky_nxt;
            clr_q  <= sticky_clr;
        end
    end

    assign pin = pin_sticky ? sticky : lol;

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (err_valid && mag > ERR_W'(SET_CNT)) |=> lol);

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (err_valid && mag <= ERR_W'(CLR_CNT)) |=> !lol);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!err_valid || (mag > ERR_W'(CLR_CNT) && mag <= ERR_W'(SET_CNT))) |=> $stable(lol));

    assert_sticky_follows_R7: assert property (@(posedge clk) disable iff (rst)
        lol |-> sticky);

    assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_q && !sticky_clr && !err_valid && !lol) |=> !sticky);
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector #(
    parameter int WINDOW  = 4000,
    parameter int DIV_W   = 2,
    parameter int PPM_SET = 1000,
    parameter int PPM_CLR = 250,
    localparam int CNT_W  = flock_pkg::cnt_width(WINDOW, DIV_W),
    localparam int ERR_W  = CNT_W + 1
) (
    input  logic                    clk_sys,
    input  logic                    rst,
    input  logic                    clk_osc,
    input  logic                    clk_data,
    input  logic                    clk_ref,
    input  logic                    cfg_ref_mode,
    input  logic [DIV_W-1:0]        cfg_div,
    input  logic                    cfg_sticky_clr,
    input  logic                    cfg_pin_sticky,
    output logic                    lol_pin,
    output logic                    lol_live,
    output logic                    stat_sticky,
    output logic signed [ERR_W-1:0] err_sample,
    output logic                    err_valid
);
    localparam int NSRC    = 3;
    localparam int SET_CNT = flock_pkg::ppm_to_cnt(WINDOW, PPM_SET);
    localparam int CLR_CNT = flock_pkg::ppm_to_cnt(WINDOW, PPM_CLR);

    logic [NSRC-1:0] src_clk;
    logic [CNT_W-1:0] src_gray [NSRC];
    logic [CNT_W-1:0] src_bin  [NSRC];

    assign src_clk = {clk_ref, clk_data, clk_osc};

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        flock_gray_cnt #(.W(CNT_W)) u_cnt (
            .clk (src_clk[k]),
            .rst (rst),
            .gray(src_gray[k])
        );
        flock_gray_sync #(.W(CNT_W)) u_sync (
            .clk    (clk_sys),
            .rst    (rst),
            .gray_in(src_gray[k]),
            .bin_out(src_bin[k])
        );
    end

    flock_window #(
        .WINDOW(WINDOW), .DIV_W(DIV_W), .CNT_W(CNT_W), .ERR_W(ERR_W)
    ) u_window (
        .clk       (clk_sys),
        .rst       (rst),
        .ref_mode  (cfg_ref_mode),
        .div       (cfg_div),
        .osc_now   (src_bin[0]),
        .dat_now   (src_bin[1]),
        .ref_now   (src_bin[2]),
        .err_sample(err_sample),
        .err_valid (err_valid)
    );

    flock_lol #(
        .ERR_W(ERR_W), .SET_CNT(SET_CNT), .CLR_CNT(CLR_CNT)
    ) u_lol (
        .clk       (clk_sys),
        .rst       (rst),
        .err       (err_sample),
        .err_valid (err_valid),
        .sticky_clr(cfg_sticky_clr),
        .pin_sticky(cfg_pin_sticky),
        .lol       (lol_live),
        .sticky    (stat_sticky),
        .pin       (lol_pin)
    );

    assert_reset_state_R6: assert property (@(posedge clk_sys)
        $past(rst) |-> (lol_live && stat_sticky && !err_valid));
endmodule

// File: tb/freq_lock_detector_test.sv
`timescale 1ps/1ps
module freq_lock_detector_test;
    localparam int WIN   = 4000;
    localparam int ERR_W = 18;
    localparam int P_OSC = 12000;

    typedef struct {
        bit    skip;
        real   ideal;
        string tag;
    } item_t;

    logic clk_sys = 0, clk_osc = 0, clk_data = 0, clk_ref = 0;
    logic rst = 1;
    logic cfg_ref_mode = 0, cfg_sticky_clr = 0, cfg_pin_sticky = 0;
    logic [1:0] cfg_div = 0;
    logic lol_pin, lol_live, stat_sticky, err_valid;
    logic signed [ERR_W-1:0] err_sample;

    int p_dat = 12000;
    int p_ref = 24000;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit lol_m = 1, sticky_m = 1;
    item_t q[$];

    freq_lock_detector uut (
        .clk_sys(clk_sys), .rst(rst), .clk_osc(clk_osc), .clk_data(clk_data),
        .clk_ref(clk_ref), .cfg_ref_mode(cfg_ref_mode), .cfg_div(cfg_div),
        .cfg_sticky_clr(cfg_sticky_clr), .cfg_pin_sticky(cfg_pin_sticky),
        .lol_pin(lol_pin), .lol_live(lol_live), .stat_sticky(stat_sticky),
        .err_sample(err_sample), .err_valid(err_valid)
    );

    always #5000 clk_sys = ~clk_sys;
    always begin #(P_OSC/2) clk_osc = 1; #(P_OSC - P_OSC/2) clk_osc = 0; end
    always begin #(p_dat/2) clk_data = 1; #(p_dat - p_dat/2) clk_data = 0; end
    always begin #(p_ref/2) clk_ref = 1; #(p_ref - p_ref/2) clk_ref = 0; end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endfunction

    // watchdog
    always @(posedge clk_sys) begin
        cyc <= cyc + 1;
        if (cyc > 195000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
            finish_run();
        end
    end

    // monitor: pops expected items and compares with each new sample
    always begin
        @(negedge clk_sys);
        if (!rst && err_valid) begin
            item_t it;
            int    e, mag;
            string ltag;
            e = int'(err_sample);
            if (q.size() > 0) it = q.pop_front();
            else begin it.skip = 1; it.ideal = 0.0; it.tag = "R4"; end
            if (!it.skip) begin
                real d;
                d = real'(e) - it.ideal;
                chk(d < 2.5 && d > -2.5, it.tag, "error sample", e, longint'(it.ideal));
            end
            mag = (e < 0) ? -e : e;
            if (mag > 4)       begin lol_m = 1; ltag = "R1"; end
            else if (mag <= 1) begin lol_m = 0; ltag = "R2"; end
            else               ltag = "R3";
            if (lol_m) sticky_m = 1;
            @(negedge clk_sys);
            chk(lol_live == lol_m, ltag, "lol_live", lol_live, lol_m);
            chk(stat_sticky == sticky_m, "R7", "stat_sticky", stat_sticky, sticky_m);
            chk(lol_pin == (cfg_pin_sticky ? sticky_m : lol_m), "R9", "lol_pin",
                lol_pin, cfg_pin_sticky ? sticky_m : lol_m);
            chk(err_valid == 0, "R10", "strobe width", err_valid, 0);
        end
    end

    // driver: change the comparison clock, push one skipped and n checked items
    task automatic run_case(input bit ref_m, input int div, input int per,
                            input int n, input string tag);
        item_t it;
        real   cnt;
        cfg_ref_mode = ref_m;
        cfg_div      = 2'(div);
        if (ref_m) p_ref = per; else p_dat = per;
        cnt = real'(WIN) * real'(1 << div) * real'(P_OSC) / real'(per);
        it.skip = 1; it.ideal = 0.0; it.tag = tag;
        q.push_back(it);
        for (int i = 0; i < n; i++) begin
            it.skip = 0; it.ideal = cnt - real'(WIN); it.tag = tag;
            q.push_back(it);
        end
        while (q.size() > 0) @(negedge clk_sys);
        repeat (4) @(negedge clk_sys);
    endtask

    task automatic clear_sticky(input bit exp_val);
        @(negedge clk_sys) cfg_sticky_clr = 1;
        repeat (3) @(negedge clk_sys);
        cfg_sticky_clr = 0;
        repeat (2) @(negedge clk_sys);
        sticky_m = exp_val;
        chk(stat_sticky == exp_val, "R8", "sticky after clear", stat_sticky, exp_val);
    endtask

    initial begin
        repeat (3) @(negedge clk_sys);
        chk(lol_live == 1, "R6", "reset lol_live", lol_live, 1);
        chk(stat_sticky == 1, "R6", "reset stat_sticky", stat_sticky, 1);
        chk(lol_pin == 1, "R6", "reset lol_pin", lol_pin, 1);
        chk(err_valid == 0, "R6", "reset err_valid", err_valid, 0);
        repeat (20) @(negedge clk_sys);
        rst = 0;
        @(negedge clk_sys);
        chk(lol_live == 1, "R6", "post-reset lol_live", lol_live, 1);

        run_case(0, 0, 12000, 2, "R4");          // on frequency: lock
        clear_sticky(0);                          // R8 clear while locked
        cfg_pin_sticky = 1;
        @(negedge clk_sys);
        chk(lol_pin == 0, "R9", "pin shows cleared sticky", lol_pin, 0);
        cfg_pin_sticky = 0;
        run_case(0, 0, 11991, 2, "R4");          // +750 ppm, inside band
        run_case(0, 0, 11976, 2, "R4");          // +2000 ppm: lose lock
        cfg_pin_sticky = 1;
        run_case(0, 0, 11991, 2, "R4");          // band again: hold high
        run_case(0, 0, 12024, 1, "R4");          // -2000 ppm
        clear_sticky(1);                          // R8 clear collides with active loss
        run_case(0, 0, 12000, 2, "R4");          // relock, sticky persists (R7)
        chk(lol_pin == 1, "R9", "pin on sticky after relock", lol_pin, 1);
        cfg_pin_sticky = 0;
        @(negedge clk_sys);
        chk(lol_pin == lol_live, "R9", "pin on live after relock", lol_pin, lol_live);
        run_case(1, 1, 24000, 1, "R5");          // reference mode on rate
        run_case(1, 1, 23952, 1, "R5");          // reference 2000 ppm off
        finish_run();
    end
endmodule